// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is a small memory-mapped timer. A 5-bit prescaler divides a selectable count source, and each time the prescaler passes zero an 8-bit decrementer steps down by one. When the decrementer passes zero it reloads from its own reload register and the block emits a one-cycle interrupt request pulse, which feeds the middle-priority input of a separate interrupt controller. The count source is either an internal clock-enable strobe or an external clock pin. The pin is synchronized through two flops and counts on its rising edges.

Software sees two register addresses, and reads and writes mean different things at each. Writing the data address sets the decrementer reload value. Reading it returns the live decrementer. Writing the control address sets the prescaler reload, the source select and the run/stop bit. A run write reloads both counters at once. Reading the control address returns a capture latch, which holds the decrementer value taken on the rising edge of a separate capture input.

Internally a two-state machine governs counting. The states are `ST_HALT` and `ST_RUN`. The transitions are T_START (`ST_HALT` to `ST_RUN` on a control write with the run bit set), T_RESTART (`ST_RUN` to `ST_RUN` on the same write, which reloads both counters), T_STOP (any state to `ST_HALT` on a control write with the run bit clear) and T_KEEP (no control write, state held).

Top module: `pdt_timer`

## Requirements
- R1: After reset the data read (bus_sel=0) and the control read (bus_sel=1) both return 0xFF, irq_pulse is 0, the timer is halted, and the prescaler reload is 0x1F.
- R2: A write with bus_sel=0 sets the decrementer reload value and does not change the live count, whether the timer is halted or running. A read with bus_sel=0 returns the live count.
- R3: A write with bus_sel=1 and bit 7 = 1 loads the prescaler from bits 4:0 of that byte and the decrementer from the reload register, then starts counting.
- R4: A write with bus_sel=1 and bit 7 = 0 stops counting and holds the count. Bit 5 of a control write has no effect.
- R5: With bit 6 = 0 the source is int_tick. The prescaler steps once per tick and the decrementer steps once per (prescale+1) ticks, so one full period is (prescale+1)×(reload+1) ticks.
- R6: When the decrementer steps past zero, it reloads from the reload register. irq_pulse is 1 for exactly the cycle after the clock edge that took that step.
- R7: With bit 6 = 1 the source is the rising edge of ext_clk after a two-flop synchronizer, so the count changes on the third clock edge after the pin rises. int_tick has no effect in this mode, and a pin held high counts only once.
- R8: A rising edge of cap_in latches the live count into the capture latch, and a read with bus_sel=1 returns the latch. Between capture edges the latch holds its value.
- R9: A control write wins over a source tick in the same cycle: the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: live count (sel 0) or capture latch (sel 1) |
| int_tick | input | 1 | Internal count enable, one tick per high cycle |
| ext_clk | input | 1 | Asynchronous external count pin |
| cap_in | input | 1 | Capture trigger, latched on its rising edge |
| irq_pulse | output | 1 | One-cycle request on decrementer underflow |

## Verification
Register writes, internal ticks and capture edges each take effect at the very next rising edge. The read data is combinational from registers, so the bench samples it at the following falling edge. irq_pulse also appears one edge after the underflowing tick and is sampled in that same half cycle. An external pin rise takes effect on the third edge after it, so the bench checks that the count has not yet moved after two edges and has moved after three. The random phase drives int_tick on falling edges and counts the ticks it issued. It then predicts the count and the number of requests from the period formula, and the final tick's effects have settled before any sample is taken.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    // Counting state of the timer
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    // Register select values on the bus
    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/pdt_tick_src.sv
module pdt_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_tick,
    input  logic ext_pin,
    input  logic use_ext,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   edge_prev;
    logic                   ext_rise;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_prev <= 1'b0;
        else        edge_prev <= sync_q[SYNC_STAGES-1];
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~edge_prev;
    assign tick     = use_ext ? ext_rise : int_tick;

    // R7: an edge detector cannot fire on two cycles in a row
    a_r7_ext_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/pdt_core.sv
module pdt_core
    import pdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PSC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             use_ext,
    output logic             irq
);
    localparam int RUN_BIT = CNT_W - 1;
    localparam int SRC_BIT = CNT_W - 2;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_rld;
    logic [PSC_W-1:0] psc_q, psc_d, psc_rld;
    logic             irq_q, irq_d;
    logic             src_q;
    logic             go_wr, stop_wr, step;
    logic             ctrl_unused;

    assign go_wr       = wr_ctrl &  wdata[RUN_BIT];
    assign stop_wr     = wr_ctrl & ~wdata[RUN_BIT];
    assign ctrl_unused = ^wdata[SRC_BIT-1:PSC_W];
    assign step        = (state_q == ST_RUN) & tick & ~wr_ctrl;

    // Next-state: T_START / T_RESTART / T_STOP / T_KEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (go_wr)   state_d = ST_RUN;
            ST_RUN:  if (stop_wr) state_d = ST_HALT;
            default:              state_d = ST_HALT;
        endcase
    end

    // Counter and request outputs
    always_comb begin
        cnt_d = cnt_q;
        psc_d = psc_q;
        irq_d = 1'b0;
        if (go_wr) begin
            cnt_d = cnt_rld;
            psc_d = wdata[PSC_W-1:0];
        end else if (step) begin
            if (psc_q == '0) begin
                psc_d = psc_rld;
                if (cnt_q == '0) begin
                    cnt_d = cnt_rld;
                    irq_d = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end else begin
                psc_d = psc_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
            psc_q <= '1;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            psc_q <= psc_d;
            irq_q <= irq_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_rld <= '1;
            psc_rld <= '1;
            src_q   <= 1'b0;
        end else begin
            if (wr_data) cnt_rld <= wdata;
            if (wr_ctrl) begin
                psc_rld <= wdata[PSC_W-1:0];
                src_q   <= wdata[SRC_BIT];
            end
        end
    end

    assign cnt     = cnt_q;
    assign irq     = irq_q;
    assign use_ext = src_q;

    // R3: a run write loads both counters
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        go_wr |=> (cnt_q == $past(cnt_rld)) && (psc_q == $past(wdata[PSC_W-1:0])));
    // R4: halted and not started means nothing moves
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !go_wr) |=> $stable(cnt_q) && $stable(psc_q));
    // R5: a tick with the prescaler above zero only moves the prescaler
    a_r5_presc_only: assert property (@(posedge clk) disable iff (!rst_n)
        (step && psc_q != '0) |=> (cnt_q == $past(cnt_q)) && (psc_q == $past(psc_q) - 1'b1));
    // R6: a request comes only from an underflow and leaves the count reloaded
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(step && psc_q == '0 && cnt_q == '0));
    a_r6_irq_reload: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> cnt_q == $past(cnt_rld));
    // R9: a control write suppresses the tick of the same cycle
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !irq_q);
endmodule

// File: rtl/pdt_capture.sv
module pdt_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val
);
    logic             cap_prev;
    logic             cap_rise;
    logic [CNT_W-1:0] cap_q;

    assign cap_rise = cap_in & ~cap_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_prev <= 1'b0;
            cap_q    <= '1;
        end else begin
            cap_prev <= cap_in;
            if (cap_rise) cap_q <= cnt;
        end
    end

    assign cap_val = cap_q;

    // R8: a capture edge takes the live count, otherwise the latch holds
    a_r8_take: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rise |=> cap_q == $past(cnt));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise |=> $stable(cap_q));
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             int_tick,
    input  logic             ext_clk,
    input  logic             cap_in,
    output logic             irq_pulse
);
    logic             wr_data, wr_ctrl;
    logic             tick, use_ext;
    logic [CNT_W-1:0] cnt, cap_val;

    assign wr_data = bus_wr & (bus_sel == SEL_DATA);
    assign wr_ctrl = bus_wr & (bus_sel == SEL_CTRL);

    pdt_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_tick (int_tick),
        .ext_pin  (ext_clk),
        .use_ext  (use_ext),
        .tick     (tick)
    );

    pdt_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata),
        .tick    (tick),
        .cnt     (cnt),
        .use_ext (use_ext),
        .irq     (irq_pulse)
    );

    pdt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .cnt     (cnt),
        .cap_val (cap_val)
    );

    assign bus_rdata = (bus_sel == SEL_CTRL) ? cap_val : cnt;

    // R1: no request while reset has just released the block
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_pulse);
endmodule

// File: tb/tb_pdt_timer.sv
module tb_pdt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       int_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       cap_in = 1'b0;
    logic       irq_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pdt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_tick(int_tick),
        .ext_clk(ext_clk), .cap_in(cap_in), .irq_pulse(irq_pulse)
    );

    always @(negedge clk) if (irq_pulse) irq_seen++;

    function automatic int exp_count(int p, int r, int n);
        int d = n / (p + 1);
        return r - (d % (r + 1));
    endfunction

    function automatic int exp_irqs(int p, int r, int n);
        return (n / (p + 1)) / (r + 1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output int v);
        bus_sel = sel;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic ticks(int n);
        if (n > 0) begin
            int_tick = 1'b1;
            repeat (n) @(negedge clk);
            int_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check("R1 data read", v, 8'hFF);
        rd(1'b1, v); check("R1 ctrl read", v, 8'hFF);
        check("R1 irq", int'(irq_pulse), 0);
        ticks(6);
        rd(1'b0, v); check("R1 halted after reset", v, 8'hFF);

        // R2 reload write while halted leaves count
        wr(1'b0, 8'd5);
        rd(1'b0, v); check("R2 halted reload write", v, 8'hFF);

        // R3 start with prescale 2
        wr(1'b1, 8'h82);
        rd(1'b0, v); check("R3 loaded count", v, 5);
        ticks(2);
        rd(1'b0, v); check("R5 prescaler absorbs ticks", v, 5);
        ticks(1);
        rd(1'b0, v); check("R5 decrement after p+1 ticks", v, 4);

        // R2 reload write while running leaves count
        wr(1'b0, 8'd2);
        rd(1'b0, v); check("R2 running reload write", v, 4);

        // R4 stop with bit 5 set
        wr(1'b1, 8'h20);
        ticks(10);
        rd(1'b0, v); check("R4 stopped count held", v, 4);

        // R6 underflow with p=0, r=2
        wr(1'b1, 8'h80);
        rd(1'b0, v); check("R3 restart takes new reload", v, 2);
        ticks(2);
        rd(1'b0, v); check("R6 count at zero", v, 0);
        check("R6 no request before underflow", int'(irq_pulse), 0);
        ticks(1);
        check("R6 request after underflow", int'(irq_pulse), 1);
        rd(1'b0, v); check("R6 reload on underflow", v, 2);
        @(negedge clk);
        check("R6 request lasts one cycle", int'(irq_pulse), 0);

        // R8 capture
        cap_in = 1'b1; @(negedge clk); cap_in = 1'b0;
        rd(1'b1, v); check("R8 captured value", v, 2);
        ticks(1);
        rd(1'b0, v); check("R8 live count moved", v, 1);
        rd(1'b1, v); check("R8 latch holds", v, 2);

        // R9 control write with same-cycle tick
        wr(1'b0, 8'd5);
        int_tick = 1'b1;
        wr(1'b1, 8'h80);
        int_tick = 1'b0;
        rd(1'b0, v); check("R9 write wins over tick", v, 5);

        // R7 external source
        wr(1'b1, 8'hC0);
        ticks(7);
        rd(1'b0, v); check("R7 int_tick ignored", v, 5);
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        rd(1'b0, v); check("R7 not yet after two edges", v, 5);
        @(negedge clk);
        rd(1'b0, v); check("R7 counted on third edge", v, 4);
        repeat (5) @(negedge clk);
        rd(1'b0, v); check("R7 held level counts once", v, 4);
        ext_clk = 1'b0; repeat (3) @(negedge clk);
        ext_clk = 1'b1; repeat (4) @(negedge clk);
        rd(1'b0, v); check("R7 second rising edge", v, 3);
        ext_clk = 1'b0;
        wr(1'b1, 8'h00);

        // R5/R6 random periods on the internal source
        for (int it = 0; it < 12; it++) begin
            int p = int'($urandom % 4);
            int r = int'($urandom % 6);
            int n = 0;
            int base;
            int len = 40 + int'($urandom % 60);
            logic [7:0] cw;
            wr(1'b0, 8'(r));
            cw = 8'h80 | 8'(p);
            if ($urandom % 2 == 1) cw = cw | 8'h20;
            base = irq_seen;
            wr(1'b1, cw);
            for (int c = 0; c < len; c++) begin
                int t = int'($urandom % 2);
                int_tick = t[0];
                @(negedge clk);
                n += t;
            end
            int_tick = 1'b0;
            @(negedge clk);
            rd(1'b0, v); check("R5 random count", v, exp_count(p, r, n));
            check("R6 random request count", irq_seen - base, exp_irqs(p, r, n));
            wr(1'b1, 8'h00);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule